// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block keeps the interrupt bookkeeping of a network controller. Hardware events arrive each cycle as a vector of cause bits and are latched into a cause register. A mask register selects which causes may interrupt. Software reaches both registers, their set and clear aliases, an auto-mask register, a small control register and a throttle interval through a single-cycle register access port. The block delivers interrupts in one of two ways. In legacy mode it drives a level line. In message mode it drives a one-cycle pulse.

A message is produced only for causes that become newly enabled and pending. A cause counts as newly enabled and pending when it is set in both the cause and the mask register after an update and was not set in both before. That update can be a hardware event, a write through the cause-set alias, or a write that sets mask bits. Reading the cause register can clear it. This depends on the mask contents, the per-vector mode flag and the acknowledge-auto-mask option. A throttle timer holds back deliveries for a programmed interval after each one. When the interval ends, the block delivers again if an enabled cause is still pending.

Register map, by the 3-bit access address:

- 0: cause register.
- 1: cause-set alias.
- 2: mask set. Reads return the mask.
- 3: mask clear. Reads return 0.
- 4: auto-mask register.
- 5: control register. Bit 0 selects message mode, bit 1 enables per-vector mode, bit 2 enables acknowledge-auto-mask.
- 6: throttle interval.

Bit 31 of the cause register is a summary flag. The block sets it whenever it delivers an interrupt. Bit 31 can never be set in the mask register.

Top module: `intr_cause_ctrl`

## Requirements
- R1: After reset, every register reads 0, the level line is low and no pulse is issued.
- R2: A hardware event bit, or a 1 written to the cause-set alias (address 1), sets that cause bit. When an event and a software clear hit the same bit in the same cycle, the bit ends up set.
- R3: In message mode (control bit 0 = 1), the pulse output is high for one cycle, one cycle after an update, only if that update made some bit of 30:0 set in both mask and cause that was not set in both before. A repeat event on a bit that is already pending and enabled gives no pulse.
- R4: Writing ones to mask set (address 2) runs the same new-pending check as a hardware event, and delivers an interrupt for causes that were already pending.
- R5: Writing ones to mask clear (address 3) clears those mask bits. In legacy mode the line falls on the next cycle if no enabled cause remains.
- R6: Reading the cause-set alias returns the cause register value and clears nothing.
- R7: A read of the cause register (address 0) returns the old value one cycle later. The register is then cleared entirely if the mask is zero or if per-vector mode (control bit 1) is off. Otherwise it is kept, unless R8 applies.
- R8: Bit 31 of the cause register is set on every delivery. If bit 31 is set and acknowledge-auto-mask (control bit 2) is on, a cause read clears the whole cause register and also clears the mask bits held in the auto-mask register (address 4). A cause write in the same state also clears those mask bits.
- R9: Writing ones to the cause register clears those bits. If bit 24 is among them, bits 6, 20, 21 and 22 are cleared as well.
- R10: In legacy mode the line rises one cycle after a delivery and falls one cycle after no enabled cause remains. In message mode the line stays low.
- R11: After each delivery, with a nonzero interval N (address 6, bits 15:0), further deliveries are held back for N × TICK_DIV cycles. In the last cycle of that window the block delivers again if an enabled cause is pending. If N is 0, there is no hold-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_event | input | 32 | Per-cycle cause event bits; bit 31 is ignored |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | Register address |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid the cycle after a read; 0 otherwise |
| irq_line | output | 1 | Legacy level interrupt |
| msg_pulse | output | 1 | One-cycle message interrupt |

## Verification
The block has three kinds of result, and each has a fixed latency. Read data and both interrupt outputs come from registers, so each appears one cycle after the edge that captured the stimulus. A delivery held by the throttle appears one cycle after the edge at which the window counter reaches its last count. The bench drives inputs on the falling edge and lets a behavioural model advance on the rising edge. It compares outputs on the next falling edge, so every comparison lands on the cycle where the result is due. Directed checks count throttle edges explicitly to place the deferred pulse.

// File: rtl/icm_pkg.sv
package icm_pkg;
    localparam int DW        = 32;
    localparam int THR_W     = 16;
    localparam int SUMM_BIT  = 31;
    localparam int OTHER_BIT = 24;

    localparam logic [DW-1:0] VALID_MASK  = ~(DW'(1) << SUMM_BIT);
    localparam logic [DW-1:0] OTHER_GROUP = (DW'(1) << 6) | (DW'(1) << 20) |
                                            (DW'(1) << 21) | (DW'(1) << 22);

    typedef enum logic [2:0] {
        A_CAUSE     = 3'd0,
        A_CAUSE_SET = 3'd1,
        A_MASK_SET  = 3'd2,
        A_MASK_CLR  = 3'd3,
        A_AUTOMASK  = 3'd4,
        A_CTRL      = 3'd5,
        A_THROTTLE  = 3'd6,
        A_SPARE     = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic ack_mask_en;
        logic vec_mode;
        logic msg_mode;
    } ctrl_t;

    typedef struct packed {
        logic [DW-1:0] clr;
        logic [DW-1:0] set;
        logic [DW-1:0] mset;
        logic [DW-1:0] mclr;
    } upd_t;

    function automatic logic [DW-1:0] w1c_expand(input logic [DW-1:0] w);
        return w[OTHER_BIT] ? (w | OTHER_GROUP) : w;
    endfunction
endpackage

// File: rtl/icm_access_decode.sv
module icm_access_decode
    import icm_pkg::*;
(
    input  logic             acc_en,
    input  logic             acc_wr,
    input  logic [2:0]       acc_addr,
    input  logic [DW-1:0]    acc_wdata,
    input  logic [DW-1:0]    hw_event,
    input  logic [DW-1:0]    cause_q,
    input  logic [DW-1:0]    mask_q,
    input  logic [DW-1:0]    automask_q,
    input  ctrl_t            ctrl_q,
    input  logic [THR_W-1:0] thr_q,
    output upd_t             upd,
    output logic [DW-1:0]    rd_val,
    output logic             wr_automask,
    output logic             wr_ctrl,
    output logic             wr_throttle
);
    logic ack_ready;

    always_comb begin
        ack_ready   = cause_q[SUMM_BIT] && ctrl_q.ack_mask_en;
        upd         = '0;
        upd.set     = hw_event & VALID_MASK;
        rd_val      = '0;
        wr_automask = 1'b0;
        wr_ctrl     = 1'b0;
        wr_throttle = 1'b0;
        if (acc_en) begin
            unique case (reg_addr_e'(acc_addr))
                A_CAUSE: begin
                    if (acc_wr) begin
                        upd.clr = w1c_expand(acc_wdata);
                        if (ack_ready) upd.mclr = automask_q;
                    end else begin
                        rd_val = cause_q;
                        if (mask_q == '0 || !ctrl_q.vec_mode) begin
                            upd.clr = '1;
                        end else if (ack_ready) begin
                            upd.clr  = '1;
                            upd.mclr = automask_q;
                        end
                    end
                end
                A_CAUSE_SET: begin
                    if (acc_wr) upd.set = (hw_event | acc_wdata) & VALID_MASK;
                    else        rd_val  = cause_q;
                end
                A_MASK_SET: begin
                    if (acc_wr) upd.mset = acc_wdata;
                    else        rd_val   = mask_q;
                end
                A_MASK_CLR: begin
                    if (acc_wr) upd.mclr = acc_wdata;
                end
                A_AUTOMASK: begin
                    if (acc_wr) wr_automask = 1'b1;
                    else        rd_val      = automask_q;
                end
                A_CTRL: begin
                    if (acc_wr) wr_ctrl = 1'b1;
                    else        rd_val  = DW'(ctrl_q);
                end
                A_THROTTLE: begin
                    if (acc_wr) wr_throttle = 1'b1;
                    else        rd_val      = DW'(thr_q);
                end
                default: begin
                    rd_val = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/icm_state.sv
module icm_state
    import icm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  upd_t             upd,
    input  logic [DW-1:0]    acc_wdata,
    input  logic             rd_strobe,
    input  logic [DW-1:0]    rd_val,
    input  logic             wr_automask,
    input  logic             wr_ctrl,
    input  logic             wr_throttle,
    input  logic             set_summary,
    output logic [DW-1:0]    cause_q,
    output logic [DW-1:0]    mask_q,
    output logic [DW-1:0]    automask_q,
    output ctrl_t            ctrl_q,
    output logic [THR_W-1:0] thr_q,
    output logic [DW-1:0]    rdata_q,
    output logic             fresh,
    output logic             any_pend
);
    logic [DW-1:0] cause_n, mask_n, pend_old, pend_new;

    always_comb begin
        cause_n  = (cause_q & ~upd.clr) | upd.set;
        mask_n   = ((mask_q | upd.mset) & ~upd.mclr) & VALID_MASK;
        pend_old = cause_q & mask_q & VALID_MASK;
        pend_new = cause_n & mask_n & VALID_MASK;
        fresh    = |(pend_new & ~pend_old);
        any_pend = |pend_new;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q    <= '0;
            mask_q     <= '0;
            automask_q <= '0;
            ctrl_q     <= '0;
            thr_q      <= '0;
            rdata_q    <= '0;
        end else begin
            cause_q <= cause_n | (DW'(set_summary) << SUMM_BIT);
            mask_q  <= mask_n;
            if (wr_automask) automask_q <= acc_wdata;
            if (wr_ctrl)     ctrl_q     <= ctrl_t'(acc_wdata[$bits(ctrl_t)-1:0]);
            if (wr_throttle) thr_q      <= acc_wdata[THR_W-1:0];
            rdata_q <= rd_strobe ? rd_val : '0;
        end
    end
endmodule

// File: rtl/icm_throttle.sv
module icm_throttle #(
    parameter int THR_W    = 16,
    parameter int TICK_DIV = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             deliver,
    input  logic [THR_W-1:0] interval,
    output logic             busy,
    output logic             last
);
    localparam int CW = THR_W + $clog2(TICK_DIV + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] load;

    assign load = CW'(interval) * CW'(TICK_DIV);
    assign busy = (cnt_q != '0);
    assign last = (cnt_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst)            cnt_q <= '0;
        else if (deliver)   cnt_q <= load;
        else if (busy)      cnt_q <= cnt_q - CW'(1);
    end
endmodule

// File: rtl/icm_signal.sv
module icm_signal (
    input  logic clk,
    input  logic rst,
    input  logic fresh,
    input  logic any_pend,
    input  logic thr_busy,
    input  logic thr_last,
    input  logic msg_mode,
    output logic deliver,
    output logic irq_line,
    output logic msg_pulse
);
    assign deliver = (fresh && !thr_busy) || (thr_last && any_pend);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_line  <= 1'b0;
            msg_pulse <= 1'b0;
        end else begin
            msg_pulse <= deliver && msg_mode;
            irq_line  <= !msg_mode && (irq_line ? any_pend : deliver);
        end
    end
endmodule

// File: rtl/intr_cause_ctrl.sv
module intr_cause_ctrl
    import icm_pkg::*;
#(
    parameter int TICK_DIV = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [31:0]   hw_event,
    input  logic          acc_en,
    input  logic          acc_wr,
    input  logic [2:0]    acc_addr,
    input  logic [31:0]   acc_wdata,
    output logic [31:0]   acc_rdata,
    output logic          irq_line,
    output logic          msg_pulse
);
    upd_t             upd;
    logic [DW-1:0]    rd_val;
    logic             wr_automask, wr_ctrl, wr_throttle;
    logic [DW-1:0]    cause_q, mask_q, automask_q;
    ctrl_t            ctrl_q;
    logic [THR_W-1:0] thr_q;
    logic             fresh, any_pend, deliver;
    logic             thr_busy, thr_last;
    logic             msg_mode;

    assign msg_mode = ctrl_q.msg_mode;

    icm_access_decode i_dec (
        .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .hw_event(hw_event),
        .cause_q(cause_q), .mask_q(mask_q), .automask_q(automask_q),
        .ctrl_q(ctrl_q), .thr_q(thr_q), .upd(upd), .rd_val(rd_val),
        .wr_automask(wr_automask), .wr_ctrl(wr_ctrl), .wr_throttle(wr_throttle)
    );

    icm_state i_state (
        .clk(clk), .rst(rst), .upd(upd), .acc_wdata(acc_wdata),
        .rd_strobe(acc_en && !acc_wr), .rd_val(rd_val),
        .wr_automask(wr_automask), .wr_ctrl(wr_ctrl), .wr_throttle(wr_throttle),
        .set_summary(deliver), .cause_q(cause_q), .mask_q(mask_q),
        .automask_q(automask_q), .ctrl_q(ctrl_q), .thr_q(thr_q),
        .rdata_q(acc_rdata), .fresh(fresh), .any_pend(any_pend)
    );

    icm_throttle #(.THR_W(THR_W), .TICK_DIV(TICK_DIV)) i_thr (
        .clk(clk), .rst(rst), .deliver(deliver), .interval(thr_q),
        .busy(thr_busy), .last(thr_last)
    );

    icm_signal i_sig (
        .clk(clk), .rst(rst), .fresh(fresh), .any_pend(any_pend),
        .thr_busy(thr_busy), .thr_last(thr_last), .msg_mode(msg_mode),
        .deliver(deliver), .irq_line(irq_line), .msg_pulse(msg_pulse)
    );
endmodule

// File: rtl/icm_checker.sv
module icm_checker
    import icm_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          acc_en,
    input logic          acc_wr,
    input logic [2:0]    acc_addr,
    input logic [31:0]   acc_wdata,
    input logic          irq_line,
    input logic          msg_pulse,
    input logic [31:0]   cause_q,
    input logic [31:0]   mask_q,
    input logic          msg_mode,
    input logic          thr_busy,
    input logic          thr_last
);
    AST_LINE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        irq_line |-> (|(mask_q & cause_q & VALID_MASK))); // R10
    AST_LINE_OFF_IN_MSG: assert property (@(posedge clk) disable iff (rst)
        irq_line |-> !$past(msg_mode)); // R10
    AST_PULSE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        msg_pulse |-> (|(mask_q & cause_q & VALID_MASK))); // R3
    AST_PULSE_IN_MSG_MODE: assert property (@(posedge clk) disable iff (rst)
        msg_pulse |-> $past(msg_mode)); // R3
    AST_THROTTLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (thr_busy && !thr_last) |=> !msg_pulse); // R11
    AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (acc_en && acc_wr && acc_addr == 3'd3) |=> ((mask_q & $past(acc_wdata)) == '0)); // R5
    AST_ALIAS_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !acc_wr && acc_addr == 3'd1) |=> ((cause_q & $past(cause_q)) == $past(cause_q))); // R6
endmodule

bind intr_cause_ctrl icm_checker i_chk (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .irq_line(irq_line),
    .msg_pulse(msg_pulse), .cause_q(cause_q), .mask_q(mask_q),
    .msg_mode(msg_mode), .thr_busy(thr_busy), .thr_last(thr_last)
);

// File: tb/test_intr_cause_ctrl.sv
`timescale 1ns/1ps
module test_intr_cause_ctrl;
    localparam int TD = 13;
    localparam logic [31:0] VM  = 32'h7FFF_FFFF;
    localparam logic [31:0] GRP = 32'h0070_0040;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] hw_event = '0;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [2:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        irq_line, msg_pulse;

    intr_cause_ctrl #(.TICK_DIV(TD)) i_intr_cause_ctrl (
        .clk(clk), .rst(rst), .hw_event(hw_event), .acc_en(acc_en),
        .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .irq_line(irq_line), .msg_pulse(msg_pulse)
    );

    always #10 clk = ~clk;

    int    vectors = 0;
    int    errors  = 0;
    string cur_req = "R1";
    bit    started = 0;

    // behavioural reference state
    logic [31:0] m_cause, m_mask, m_am, m_rdata;
    logic [2:0]  m_ctrl;
    logic [15:0] m_thr;
    int          m_cnt;
    logic        m_line, m_pulse;

    always @(posedge clk) begin
        logic [31:0] clr, setv, mset, mclr, rd, nc, nm, oldp, newp;
        bit ackr, fresh, anyp, dlv;
        if (rst) begin
            m_cause = 0; m_mask = 0; m_am = 0; m_rdata = 0; m_ctrl = 0;
            m_thr = 0; m_cnt = 0; m_line = 0; m_pulse = 0;
        end else begin
            clr = 0; mset = 0; mclr = 0; rd = 0;
            setv = hw_event & VM;
            ackr = m_cause[31] && m_ctrl[2];
            if (acc_en) begin
                case (acc_addr)
                    3'd0: if (acc_wr) begin
                              clr = acc_wdata;
                              if (acc_wdata[24]) clr = clr | GRP;
                              if (ackr) mclr = m_am;
                          end else begin
                              rd = m_cause;
                              if (m_mask == 0 || !m_ctrl[1]) clr = '1;
                              else if (ackr) begin clr = '1; mclr = m_am; end
                          end
                    3'd1: if (acc_wr) setv = (setv | acc_wdata) & VM; else rd = m_cause;
                    3'd2: if (acc_wr) mset = acc_wdata; else rd = m_mask;
                    3'd3: if (acc_wr) mclr = acc_wdata;
                    3'd4: if (!acc_wr) rd = m_am;
                    3'd5: if (!acc_wr) rd = {29'b0, m_ctrl};
                    3'd6: if (!acc_wr) rd = {16'b0, m_thr};
                    default: rd = 0;
                endcase
            end
            nc   = (m_cause & ~clr) | setv;
            nm   = ((m_mask | mset) & ~mclr) & VM;
            oldp = m_cause & m_mask & VM;
            newp = nc & nm & VM;
            fresh = (newp & ~oldp) != 0;
            anyp  = newp != 0;
            dlv   = (fresh && m_cnt == 0) || (m_cnt == 1 && anyp);
            if (dlv) nc[31] = 1'b1;
            m_line  = !m_ctrl[0] && (m_line ? anyp : dlv);
            m_pulse = dlv && m_ctrl[0];
            if (dlv) m_cnt = m_thr * TD;
            else if (m_cnt != 0) m_cnt = m_cnt - 1;
            m_rdata = (acc_en && !acc_wr) ? rd : 0;
            if (acc_en && acc_wr && acc_addr == 3'd4) m_am = acc_wdata;
            if (acc_en && acc_wr && acc_addr == 3'd5) m_ctrl = acc_wdata[2:0];
            if (acc_en && acc_wr && acc_addr == 3'd6) m_thr = acc_wdata[15:0];
            m_cause = nc;
            m_mask  = nm;
            started = 1;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (started) begin
            vectors += 3;
            if (irq_line !== m_line) begin
                errors++; $display("FAIL %s irq_line act=%0b exp=%0b", cur_req, irq_line, m_line);
            end
            if (msg_pulse !== m_pulse) begin
                errors++; $display("FAIL %s msg_pulse act=%0b exp=%0b", cur_req, msg_pulse, m_pulse);
            end
            if (acc_rdata !== m_rdata) begin
                errors++; $display("FAIL %s acc_rdata act=%h exp=%h", cur_req, acc_rdata, m_rdata);
            end
        end
    end

    task automatic cyc(input logic [31:0] ev);
        hw_event = ev;
        @(negedge clk);
        hw_event = 0;
    endtask

    task automatic acc(input bit wr, input logic [2:0] a, input logic [31:0] d, input logic [31:0] ev);
        acc_en = 1; acc_wr = wr; acc_addr = a; acc_wdata = d; hw_event = ev;
        @(negedge clk);
        acc_en = 0; acc_wr = 0; acc_wdata = 0; hw_event = 0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++; $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
        acc(0, a, 0, 0);
        chk(req, acc_rdata, exp);
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            errors++;
            $display("FAIL watchdog act=%0d exp=<150000", wd);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int pulses, first_at;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        cur_req = "R1";
        chk("R1", {30'b0, irq_line, msg_pulse}, 0);
        for (int a = 0; a < 7; a++) rd_chk(3'(a), 0, "R1");

        // R2, R6 event latch and alias read without clear
        cur_req = "R6";
        cyc(32'h8);
        rd_chk(1, 32'h8, "R6");
        rd_chk(1, 32'h8, "R6");
        chk("R6", {31'b0, irq_line}, 0);

        // R4, R10 mask set delivers pending cause on legacy line
        cur_req = "R4";
        acc(1, 2, 32'h8, 0);
        chk("R4", {31'b0, irq_line}, 1);
        rd_chk(1, 32'h8000_0008, "R8");

        // R5 mask clear drops line
        cur_req = "R5";
        acc(1, 3, 32'h8, 0);
        chk("R5", {31'b0, irq_line}, 0);
        rd_chk(2, 0, "R5");

        // R7 read with zero mask clears everything
        cur_req = "R7";
        rd_chk(0, 32'h8000_0008, "R7");
        rd_chk(1, 0, "R7");

        // R9 other-bit group clear
        cur_req = "R9";
        acc(1, 1, 32'h0110_0048, 0);
        acc(1, 0, 32'h0100_0000, 0);
        rd_chk(1, 32'h8, "R9");

        // R2 event wins over same-cycle clear
        cur_req = "R2";
        acc(1, 0, 32'h8, 32'h8);
        rd_chk(1, 32'h8, "R2");
        acc(1, 0, 32'h8, 0);
        rd_chk(1, 0, "R2");

        // R10 level line follows enabled pending
        cur_req = "R10";
        acc(1, 2, 32'h4, 0);
        cyc(32'h4);
        chk("R10", {31'b0, irq_line}, 1);
        acc(1, 0, 32'h4, 0);
        chk("R10", {31'b0, irq_line}, 0);

        // R3 message mode, new-pending only
        cur_req = "R3";
        acc(1, 5, 32'h3, 0);
        cyc(32'h4);
        chk("R3", {31'b0, msg_pulse}, 1);
        chk("R10", {31'b0, irq_line}, 0);
        cyc(32'h4);
        chk("R3", {31'b0, msg_pulse}, 0);
        cyc(32'h2);
        chk("R3", {31'b0, msg_pulse}, 0);
        cur_req = "R4";
        acc(1, 2, 32'h2, 0);
        chk("R4", {31'b0, msg_pulse}, 1);

        // R7 per-vector mode with mask set keeps cause
        cur_req = "R7";
        rd_chk(0, 32'h8000_0006, "R7");
        rd_chk(1, 32'h8000_0006, "R7");

        // R8 acknowledge auto-mask on read and on write
        cur_req = "R8";
        acc(1, 4, 32'h2, 0);
        acc(1, 5, 32'h7, 0);
        rd_chk(0, 32'h8000_0006, "R8");
        rd_chk(1, 0, "R8");
        rd_chk(2, 32'h4, "R8");
        cyc(32'h4);
        acc(1, 4, 32'h4, 0);
        acc(1, 0, 32'h0, 0);
        rd_chk(2, 0, "R8");
        rd_chk(1, 32'h8000_0004, "R8");

        // R11 throttle postpones and re-issues at window end
        cur_req = "R11";
        acc(1, 5, 32'h3, 0);
        acc(1, 0, 32'hFFFF_FFFF, 0);
        acc(1, 2, 32'h1, 0);
        acc(1, 6, 32'h2, 0);
        cyc(32'h1);
        chk("R11", {31'b0, msg_pulse}, 1);
        acc(1, 0, 32'h1, 0);
        cyc(32'h1);
        chk("R11", {31'b0, msg_pulse}, 0);
        pulses = 0; first_at = -1;
        for (int i = 0; i < 40; i++) begin
            cyc(0);
            if (msg_pulse) begin
                pulses++;
                if (first_at < 0) first_at = i;
            end
        end
        chk("R11", 32'(pulses), 1);
        chk("R11", 32'(first_at), 23);
        acc(1, 0, 32'h1, 0);
        pulses = 0;
        for (int i = 0; i < 20; i++) begin
            cyc(0);
            if (msg_pulse) pulses++;
        end
        chk("R11", 32'(pulses), 0);
        acc(1, 6, 32'h0, 0);
        cyc(32'h1);
        chk("R11", {31'b0, msg_pulse}, 1);
        acc(1, 0, 32'h1, 0);
        cyc(32'h1);
        chk("R11", {31'b0, msg_pulse}, 1);

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule